// File: doc/BRIEF.md
# Triggered Trapezoid DAC Pulse Generator

This block produces one signed DAC sample code per sample clock. Two 32-bit configuration words control it. The data word carries a pulse amplitude and a baseline level. The control word selects among three output behaviours:

- a constant output at the amplitude;
- a square pulse that follows an external trigger;
- a trapezoid started by each trigger rising edge. The trapezoid ramps linearly from the baseline toward the amplitude, holds for a programmable number of samples, then ramps back to the baseline.

The external trigger is asynchronous. It passes through a two-flop synchronizer before it is used. The engine produces a signed level, and a registered output stage turns it into the final code. That stage can convert negative values to ones-complement, can invert every bit, and forces the code to zero when the output is disabled. A companion flag reports the power-down condition to the converter.

Top module: `trap_dac_gen`

## Requirements
- R1: After reset, `dac_code` is 0 and `dac_pwrdn` is 1.
- R2: `dac_pwrdn` is the inverse of control bit 0 as it stood one clock earlier. While control bit 0 was 0 on the previous clock, `dac_code` is 0.
- R3: With control bit 4 at 0, the output follows the signed amplitude in data bits 15..0, two clocks later, and the trigger has no effect.
- R4: With control bit 4 at 1 and control bit 5 at 0, the level is the amplitude while the synchronized trigger is high and the baseline (data bits 31..16) otherwise. A change on `trig_in` reaches `dac_code` at the fourth rising clock edge after it is applied.
- R5: With control bits 4 and 5 both at 1, a synchronized trigger rising edge starts a trapezoid:
  - The level moves from the baseline toward the amplitude by the up step (control bits 31..24) on each sample, and the step that would pass the amplitude is clamped to it.
  - The amplitude is then held for a count given by control bits 15..8, plus one sample.
  - The level then moves back to the baseline by the down step (control bits 23..16) on each sample, clamped in the same way, and stays at the baseline.
- R6: A step size of 0 moves the level to its target in a single sample.
- R7: A trigger rising edge that arrives while a trapezoid is in progress has no effect. A trapezoid starts only from the idle baseline state.
- R8: Control bit 2 set makes `dac_code` the bitwise complement of the code it would otherwise have.
- R9: Control bit 3 set encodes a negative level as its ones-complement, which is the two's-complement pattern of the level minus one. Non-negative levels are unchanged. The conversion is applied before the inversion of R8.
- R10: Control bits 7..6 have no effect on the output.
- R11: An amplitude below the baseline gives a downward trapezoid with the same timing and clamping rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_word | input | 32 | Bits 15..0 hold the signed amplitude; bits 31..16 hold the signed baseline |
| ctrl_word | input | 32 | Bit 0 enables the output; bit 2 inverts the code; bit 3 selects ones-complement; bit 4 enables trigger gating; bit 5 enables the ramp; bits 15..8 set the flat top; bits 23..16 set the down step; bits 31..24 set the up step |
| trig_in | input | 1 | Asynchronous trigger |
| dac_code | output | 16 | Registered sample code |
| dac_pwrdn | output | 1 | Power-down indication, high while the output is disabled |

## Verification
The bound assertions check the following on every clock:
- the power-down flag and the forced zero code of R2;
- the level in the direct and square-gated modes;
- that the level equals the amplitude throughout the flat top and the baseline whenever the ramp engine is idle;
- that a trapezoid begins only on a synchronized rising edge and never restarts mid-pulse.

Some behaviour can only be shown by the bench scenarios, compared against a behavioural model on every clock:
- the exact sample-by-sample ramp shape, the clamping of the final step and the length of the flat top;
- the zero-step shortcut, downward pulses and the code conversions;
- that the unused control bits do nothing.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_TOP  = 2'd2,
        ST_DOWN = 2'd3
    } ramp_st_e;

    // control word single-bit positions
    localparam int CB_EN   = 0;
    localparam int CB_INV  = 2;
    localparam int CB_ONES = 3;
    localparam int CB_GATE = 4;
    localparam int CB_RAMP = 5;
    localparam int CB_TOP0 = 8;
endpackage

// File: rtl/trap_trig_sync.sv
module trap_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_lvl,
    output logic trig_rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_s;

    sync_s s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], trig_async};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trig_lvl  = s_q.sh[STAGES-1];
    assign trig_rise = s_q.sh[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/trap_ramp_engine.sv
module trap_ramp_engine #(
    parameter int DW = 16,
    parameter int RW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] amp,
    input  logic signed [DW-1:0] base,
    input  logic                 gate_en,
    input  logic                 ramp_en,
    input  logic [RW-1:0]        up_step,
    input  logic [RW-1:0]        dn_step,
    input  logic [RW-1:0]        top_len,
    input  logic                 trig_lvl,
    input  logic                 trig_rise,
    output trap_pkg::ramp_st_e   state,
    output logic signed [DW-1:0] level
);
    import trap_pkg::*;

    localparam int XW = DW + 2;

    typedef struct packed {
        ramp_st_e             st;
        logic signed [DW-1:0] lvl;
        logic [RW-1:0]        cnt;
    } eng_s;

    eng_s r_q, r_d;
    logic signed [DW-1:0] nxt;

    function automatic logic signed [DW-1:0] step_to(
        input logic signed [DW-1:0] cur,
        input logic signed [DW-1:0] tgt,
        input logic [RW-1:0]        rate
    );
        logic signed [XW-1:0] c, t, r, s;
        c = $signed({{2{cur[DW-1]}}, cur});
        t = $signed({{2{tgt[DW-1]}}, tgt});
        r = $signed({{(XW-RW){1'b0}}, rate});
        if (rate == '0) return tgt;
        if (c < t) begin
            s = c + r;
            return (s >= t) ? tgt : $signed(s[DW-1:0]);
        end
        if (c > t) begin
            s = c - r;
            return (s <= t) ? tgt : $signed(s[DW-1:0]);
        end
        return tgt;
    endfunction

    always_comb begin
        r_d = r_q;
        nxt = base;
        if (!gate_en) begin
            r_d.st  = ST_IDLE;
            r_d.lvl = amp;
            r_d.cnt = '0;
        end else if (!ramp_en) begin
            r_d.st  = ST_IDLE;
            r_d.lvl = trig_lvl ? amp : base;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (trig_rise) begin
                        nxt     = step_to(base, amp, up_step);
                        r_d.lvl = nxt;
                        if (nxt == amp) begin
                            r_d.st  = ST_TOP;
                            r_d.cnt = top_len;
                        end else begin
                            r_d.st = ST_UP;
                        end
                    end else begin
                        r_d.lvl = base;
                    end
                end
                ST_UP: begin
                    nxt     = step_to(r_q.lvl, amp, up_step);
                    r_d.lvl = nxt;
                    if (nxt == amp) begin
                        r_d.st  = ST_TOP;
                        r_d.cnt = top_len;
                    end
                end
                ST_TOP: begin
                    if (r_q.cnt == '0) begin
                        nxt     = step_to(amp, base, dn_step);
                        r_d.lvl = nxt;
                        r_d.st  = (nxt == base) ? ST_IDLE : ST_DOWN;
                    end else begin
                        r_d.lvl = amp;
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                default: begin
                    nxt     = step_to(r_q.lvl, base, dn_step);
                    r_d.lvl = nxt;
                    if (nxt == base) r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.lvl <= '0;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
    assign level = r_q.lvl;
endmodule

// File: rtl/trap_out_fmt.sv
module trap_out_fmt #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] level,
    input  logic                 out_en,
    input  logic                 invert,
    input  logic                 ones_fmt,
    output logic [DW-1:0]        code,
    output logic                 pwrdn
);
    typedef struct packed {
        logic [DW-1:0] code;
        logic          pd;
    } out_s;

    out_s o_q, o_d;
    logic [DW-1:0] conv;

    always_comb begin
        conv = (ones_fmt && level[DW-1]) ? DW'(level - 1'b1) : level;
        o_d.code = out_en ? (conv ^ {DW{invert}}) : '0;
        o_d.pd   = ~out_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.code <= '0;
            o_q.pd   <= 1'b1;
        end else begin
            o_q <= o_d;
        end
    end

    assign code  = o_q.code;
    assign pwrdn = o_q.pd;
endmodule

// File: rtl/trap_dac_gen.sv
module trap_dac_gen #(
    parameter  int DW          = 16,
    parameter  int RW          = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int CW          = trap_pkg::CB_TOP0 + 3 * RW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*DW-1:0] data_word,
    input  logic [CW-1:0]   ctrl_word,
    input  logic            trig_in,
    output logic [DW-1:0]   dac_code,
    output logic            dac_pwrdn
);
    import trap_pkg::*;

    localparam int DN0 = CB_TOP0 + RW;
    localparam int UP0 = CB_TOP0 + 2 * RW;

    logic                 trig_lvl;
    logic                 trig_rise;
    ramp_st_e             eng_state;
    logic signed [DW-1:0] eng_lvl;

    trap_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_async(trig_in),
        .trig_lvl  (trig_lvl),
        .trig_rise (trig_rise)
    );

    trap_ramp_engine #(.DW(DW), .RW(RW)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .amp      ($signed(data_word[DW-1:0])),
        .base     ($signed(data_word[2*DW-1:DW])),
        .gate_en  (ctrl_word[CB_GATE]),
        .ramp_en  (ctrl_word[CB_RAMP]),
        .up_step  (ctrl_word[UP0 +: RW]),
        .dn_step  (ctrl_word[DN0 +: RW]),
        .top_len  (ctrl_word[CB_TOP0 +: RW]),
        .trig_lvl (trig_lvl),
        .trig_rise(trig_rise),
        .state    (eng_state),
        .level    (eng_lvl)
    );

    trap_out_fmt #(.DW(DW)) u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (eng_lvl),
        .out_en  (ctrl_word[CB_EN]),
        .invert  (ctrl_word[CB_INV]),
        .ones_fmt(ctrl_word[CB_ONES]),
        .code    (dac_code),
        .pwrdn   (dac_pwrdn)
    );
endmodule

// File: rtl/trap_dac_chk.sv
module trap_dac_chk #(
    parameter int DW = 16,
    parameter int CW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*DW-1:0]      data_word,
    input logic [CW-1:0]        ctrl_word,
    input logic [DW-1:0]        dac_code,
    input logic                 dac_pwrdn,
    input trap_pkg::ramp_st_e   state,
    input logic signed [DW-1:0] lvl,
    input logic                 rise,
    input logic                 tlvl
);
    import trap_pkg::*;

    logic pv_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    AST_PD_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q |-> (dac_pwrdn == !$past(ctrl_word[CB_EN]))) else $error("pd"); // R2
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(!ctrl_word[CB_EN])) |-> (dac_code == '0)) else $error("off"); // R2
    AST_DIRECT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(!ctrl_word[CB_GATE])) |-> (lvl == $past(data_word[DW-1:0]))) else $error("direct"); // R3
    AST_GATED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(ctrl_word[CB_GATE] && !ctrl_word[CB_RAMP])) |->
        (lvl == ($past(tlvl) ? $past(data_word[DW-1:0]) : $past(data_word[2*DW-1:DW])))) else $error("gated"); // R4
    AST_TOP_AT_AMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && state == ST_TOP) |-> (lvl == $past(data_word[DW-1:0]))) else $error("top"); // R5
    AST_IDLE_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(ctrl_word[CB_GATE] && ctrl_word[CB_RAMP]) && state == ST_IDLE) |->
        (lvl == $past(data_word[2*DW-1:DW]))) else $error("idle"); // R5
    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && $past(state) == ST_IDLE && state != ST_IDLE) |-> $past(rise)) else $error("start"); // R7
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (pv_q && state == ST_UP) |-> ($past(state) == ST_IDLE || $past(state) == ST_UP)) else $error("restart"); // R7
endmodule

bind trap_dac_gen trap_dac_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_word(data_word),
    .ctrl_word(ctrl_word),
    .dac_code (dac_code),
    .dac_pwrdn(dac_pwrdn),
    .state    (eng_state),
    .lvl      (eng_lvl),
    .rise     (trig_rise),
    .tlvl     (trig_lvl)
);

// File: tb/sim_trap_dac_gen.sv
module sim_trap_dac_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_word = '0;
    logic [31:0] ctrl_word = '0;
    logic        trig_in = 1'b0;
    logic [15:0] dac_code;
    logic        dac_pwrdn;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    trap_dac_gen u0 (
        .clk(clk), .rst_n(rst_n), .data_word(data_word), .ctrl_word(ctrl_word),
        .trig_in(trig_in), .dac_code(dac_code), .dac_pwrdn(dac_pwrdn)
    );

    // behavioural reference model
    bit m_s1, m_s2, m_prev, m_rise;
    int m_st, m_lvl, m_cnt, m_amp, m_base, m_up, m_dn, m_top, m_nx, m_v;
    logic [15:0] m_code = '0;
    bit m_pd = 1;

    function automatic int toward(int cur, int tgt, int rate);
        if (rate == 0) return tgt;
        if (cur < tgt) return (cur + rate >= tgt) ? tgt : cur + rate;
        if (cur > tgt) return (cur - rate <= tgt) ? tgt : cur - rate;
        return tgt;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_st = 0; m_lvl = 0; m_cnt = 0;
            m_code = '0; m_pd = 1;
        end else begin
            // output stage uses the level from before this edge
            m_v = m_lvl;
            if (ctrl_word[3] && m_v < 0) m_v = m_v - 1;
            m_code = ctrl_word[0] ? (16'(m_v) ^ {16{ctrl_word[2]}}) : 16'h0;
            m_pd = !ctrl_word[0];
            m_rise = m_s2 && !m_prev;
            m_amp  = int'($signed(data_word[15:0]));
            m_base = int'($signed(data_word[31:16]));
            m_up = int'(ctrl_word[31:24]);
            m_dn = int'(ctrl_word[23:16]);
            m_top = int'(ctrl_word[15:8]);
            if (!ctrl_word[4]) begin
                m_st = 0; m_cnt = 0; m_lvl = m_amp;
            end else if (!ctrl_word[5]) begin
                m_st = 0; m_cnt = 0; m_lvl = m_s2 ? m_amp : m_base;
            end else if (m_st == 0) begin
                if (m_rise) begin
                    m_nx = toward(m_base, m_amp, m_up);
                    m_lvl = m_nx;
                    if (m_nx == m_amp) begin m_st = 2; m_cnt = m_top; end
                    else m_st = 1;
                end else m_lvl = m_base;
            end else if (m_st == 1) begin
                m_nx = toward(m_lvl, m_amp, m_up);
                m_lvl = m_nx;
                if (m_nx == m_amp) begin m_st = 2; m_cnt = m_top; end
            end else if (m_st == 2) begin
                if (m_cnt == 0) begin
                    m_nx = toward(m_amp, m_base, m_dn);
                    m_lvl = m_nx;
                    m_st = (m_nx == m_base) ? 0 : 3;
                end else begin
                    m_lvl = m_amp; m_cnt = m_cnt - 1;
                end
            end else begin
                m_nx = toward(m_lvl, m_base, m_dn);
                m_lvl = m_nx;
                if (m_nx == m_base) m_st = 0;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = trig_in;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, {15'd0, dac_pwrdn, dac_code}, {15'd0, m_pd, m_code});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl(bit en, bit inv, bit ones, bit gate, bit ramp,
                                        int up, int dn, int top);
        return {8'(up), 8'(dn), 8'(top), 2'b00, ramp, gate, ones, inv, 1'b0, en};
    endfunction

    function automatic logic [31:0] dat(int base, int amp);
        return {16'(base), 16'(amp)};
    endfunction

    task automatic pulse(int hi, int lo);
        trig_in = 1'b1; cyc(hi);
        trig_in = 1'b0; cyc(lo);
    endtask

    int hits, mn, others;

    initial begin
        cyc(3);
        // R1: reset state
        check("R1", {15'd0, dac_pwrdn, dac_code}, {15'd0, 1'b1, 16'h0});
        rst_n = 1'b1;
        cyc(2);
        check("R1", {15'd0, dac_pwrdn, dac_code}, {15'd0, 1'b1, 16'h0});

        // R2: enable bit drives power-down and zero code
        cur_req = "R2";
        data_word = dat(-50, 1234);
        ctrl_word = '0;
        cyc(4);
        check("R2", {31'd0, dac_pwrdn}, 32'd1);
        check("R2", {16'd0, dac_code}, 32'd0);
        ctrl_word = ctl(1, 0, 0, 0, 0, 0, 0, 0);
        cyc(3);
        check("R2", {31'd0, dac_pwrdn}, 32'd0);

        // R3: direct drive, trigger ignored
        cur_req = "R3";
        for (int i = 0; i < 5; i++) pulse(1, 2);
        check("R3", {16'd0, dac_code}, 32'd1234);

        // R4: square gating, four-edge latency
        cur_req = "R4";
        ctrl_word = ctl(1, 0, 0, 1, 0, 0, 0, 0);
        cyc(6);
        check("R4", {16'd0, dac_code}, {16'd0, 16'(-50)});
        trig_in = 1'b1;
        cyc(3);
        check("R4", {16'd0, dac_code}, {16'd0, 16'(-50)});
        cyc(1);
        check("R4", {16'd0, dac_code}, 32'd1234);
        trig_in = 1'b0;
        cyc(6);

        // R5: trapezoid with clamped steps
        cur_req = "R5";
        data_word = dat(-20, 450);
        ctrl_word = ctl(1, 0, 0, 1, 1, 100, 50, 3);
        cyc(5);
        hits = 0;
        trig_in = 1'b1; cyc(2); trig_in = 1'b0;
        for (int i = 0; i < 30; i++) begin
            cyc(1);
            if (dac_code == 16'd450) hits++;
        end
        check("R5", 32'(hits), 32'd4);
        check("R5", {16'd0, dac_code}, {16'd0, 16'(-20)});

        // R6: zero step sizes jump straight to target
        cur_req = "R6";
        ctrl_word = ctl(1, 0, 0, 1, 1, 0, 0, 2);
        cyc(3);
        hits = 0; others = 0;
        trig_in = 1'b1; cyc(2); trig_in = 1'b0;
        for (int i = 0; i < 15; i++) begin
            cyc(1);
            if (dac_code == 16'd450) hits++;
            else if (dac_code != 16'(-20)) others++;
        end
        check("R6", 32'(hits), 32'd3);
        check("R6", 32'(others), 32'd0);

        // R7: retriggers during a slow pulse are ignored
        cur_req = "R7";
        data_word = dat(0, 200);
        ctrl_word = ctl(1, 0, 0, 1, 1, 10, 10, 0);
        cyc(3);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            trig_in = 1'b1; cyc(2); trig_in = 1'b0;
            for (int k = 0; k < 4; k++) begin
                cyc(1);
                if (dac_code == 16'd200) hits++;
            end
        end
        cyc(60);
        check("R7", 32'(hits), 32'd1);

        // R8: inversion
        cur_req = "R8";
        data_word = dat(0, 1234);
        ctrl_word = ctl(1, 1, 0, 0, 0, 0, 0, 0);
        cyc(3);
        check("R8", {16'd0, dac_code}, {16'd0, ~16'd1234});

        // R9: ones-complement format, before inversion
        cur_req = "R9";
        data_word = dat(0, -100);
        ctrl_word = ctl(1, 0, 1, 0, 0, 0, 0, 0);
        cyc(3);
        check("R9", {16'd0, dac_code}, {16'd0, 16'(-101)});
        data_word = dat(0, 100);
        cyc(3);
        check("R9", {16'd0, dac_code}, 32'd100);
        data_word = dat(0, -100);
        ctrl_word = ctl(1, 1, 1, 0, 0, 0, 0, 0);
        cyc(3);
        check("R9", {16'd0, dac_code}, {16'd0, ~16'(-101)});

        // R10: unused bits 7..6 ignored
        cur_req = "R10";
        data_word = dat(5, 77);
        ctrl_word = ctl(1, 0, 0, 0, 0, 0, 0, 0) | 32'hC0;
        cyc(3);
        check("R10", {16'd0, dac_code}, 32'd77);
        ctrl_word = ctl(1, 0, 0, 1, 1, 30, 20, 1) | 32'hC0;
        cyc(3);
        pulse(2, 20);

        // R11: downward trapezoid
        cur_req = "R11";
        data_word = dat(100, -300);
        ctrl_word = ctl(1, 0, 0, 1, 1, 90, 70, 2);
        cyc(4);
        mn = 1000;
        trig_in = 1'b1; cyc(2); trig_in = 1'b0;
        for (int i = 0; i < 25; i++) begin
            cyc(1);
            if (int'($signed(dac_code)) < mn) mn = int'($signed(dac_code));
        end
        check("R11", 32'(mn), 32'(-300));
        check("R11", {16'd0, dac_code}, 32'd100);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule